// File: doc/BRIEF.md
# Bridged 64-bit Register Access Sequencer

This block carries out a single 64-bit read or write on a remote register space. The only path to that space is a bridge with 32-bit registers, reached over a local register bus with a valid/ready handshake. A caller hands the sequencer several items: a 32-bit target address, a direction bit, 64 bits of write data and the index of the remote target. The sequencer then drives the bridge data, command and status registers in a fixed order. It classifies the status word the bridge returns and answers with one completion pulse. That pulse carries a result code and, for reads, the assembled 64-bit data.

The status word can show one of three things. It can be clean. It can be all ones, which marks the remote chip as gone. It can be a recoverable fault, after which the bridge engine is reset. The sequencer keeps one alive flag per target. The dead-chip case clears that target's flag. An error reported by the local bus itself ends the sequence at once, and its code is passed through unchanged.

Top module: `bridged_access_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance up to and including the cycle of `done`. `done` is high for a single cycle, and the block is idle in the cycle after it.
- R2: A write drives its bus accesses in this order: upper data half written to offset 0x1000, lower data half written to offset 0x1004, command word written to offset 0x1008, then the status word read from offset 0x101C.
- R3: The command word is the 32-bit target address bitwise-ORed with a direction flag in bit 31. The flag is 1 for a write and 0 for a read.
- R4: A read writes the command word to 0x1008 and then reads status from 0x101C. Only when the status is clean does it go on to read 0x1000 and then 0x1004. It returns `rsp_rdata` = {first word, second word} with `rsp_code` = 0.
- R5: A status word is clean when bit 20 and bits 14:12 are all zero. A clean status ends the write with `rsp_code` = 0.
- R6: A status word of all ones clears the `target_alive` bit of the request's target. The access ends with `rsp_code` = HW_CODE (default 0xFF), and no reset write is issued.
- R7: Any other non-clean status is followed by a write of zero to offset 0x1018. The access then ends with `rsp_code` = HW_CODE, even if the bus reports an error on that reset write.
- R8: A nonzero `bus_err` on any other bus handshake ends the access in the next cycle. `rsp_code` equals that `bus_err` value, and no further bus access is issued.
- R9: A read that ends with a nonzero `rsp_code` returns `rsp_rdata` of all ones. A write returns `rsp_rdata` of zero.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values. `bus_valid` is only high while the block is busy.
- R11: `target_alive` is all ones after reset. A bit only ever falls, never rises. At most one bit falls per access, and only the bit of the access's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Remote register address |
| req_wdata | input | 64 | Write data |
| req_target | input | 2 | Index of the remote target |
| busy | output | 1 | Access in progress |
| done | output | 1 | Single-cycle completion pulse |
| rsp_code | output | 8 | 0 = success, HW_CODE = hardware fault, otherwise a passed-through bus error |
| rsp_rdata | output | 64 | Read data, valid with done |
| target_alive | output | 4 | One alive flag per target |
| bus_valid | output | 1 | Local bus access request |
| bus_ready | input | 1 | Local bus access complete |
| bus_write | output | 1 | Local bus direction, 1 = write |
| bus_addr | output | 16 | Bridge register offset |
| bus_wdata | output | 32 | Local bus write data |
| bus_rdata | input | 32 | Local bus read data, valid with bus_ready |
| bus_err | input | 8 | Local bus error code, nonzero = error, valid with bus_ready |

## Verification
The assertions watch several things on every cycle. They check that the local bus request stays steady until it is answered, and that completion is a single-cycle pulse. They check that a bus error stops all further bus traffic at once, and that a recoverable status is followed directly by the zero reset write. They also check that alive flags only fall and only one at a time, and that failed reads return all ones. The bench scenarios cover the rest. The full order of bridge accesses for each direction can only be shown there, as can the exact command word, the upper:lower data assembly and the result codes for each status class. Those scenarios include a bus error landing on each step and on the reset write itself.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WR_HI,
      ST_WR_LO,
      ST_CMD,
      ST_STAT,
      ST_RD_HI,
      ST_RD_LO,
      ST_RST,
      ST_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      STAT_CLEAN,
      STAT_DEAD,
      STAT_RECOVER
   } stat_class_e;

   // bridge register offsets; the access order over them is fixed behaviour
   localparam logic [15:0] OFS_DATA_HI = 16'h1000;
   localparam logic [15:0] OFS_DATA_LO = 16'h1004;
   localparam logic [15:0] OFS_CMD     = 16'h1008;
   localparam logic [15:0] OFS_ENG_RST = 16'h1018;
   localparam logic [15:0] OFS_STATUS  = 16'h101C;

endpackage

// File: rtl/brseq_status_classify.sv
module brseq_status_classify
   import brseq_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int ABORT_BIT = 20,
   parameter int ERR_LSB   = 12,
   parameter int ERR_BITS  = 3
) (
   input  logic [WORD_W-1:0] status,
   output stat_class_e       cls
);

   generate
      if (ABORT_BIT >= WORD_W) begin : g_bad_abort
         $error("abort bit outside status word");
      end
      if (ERR_LSB + ERR_BITS > WORD_W) begin : g_bad_err
         $error("error field outside status word");
      end
   endgenerate

   logic                abort_flag;
   logic [ERR_BITS-1:0] err_field;

   assign abort_flag = status[ABORT_BIT];
   assign err_field  = status[ERR_LSB +: ERR_BITS];

   always_comb begin
      if (&status)
         cls = STAT_DEAD;
      else if (abort_flag || (|err_field))
         cls = STAT_RECOVER;
      else
         cls = STAT_CLEAN;
   end

endmodule

// File: rtl/brseq_alive_table.sv
module brseq_alive_table #(
   parameter int NUM_TGT = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill,
   input  logic [IDX_W-1:0]   kill_idx,
   output logic [NUM_TGT-1:0] alive
);

   generate
      if (NUM_TGT > (1 << IDX_W)) begin : g_bad_idx
         $error("index width too small for target count");
      end
      for (genvar g = 0; g < NUM_TGT; g++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q <= 1'b1;
            else if (kill && (kill_idx == IDX_W'(g)))
               flag_q <= 1'b0;
         end
         assign alive[g] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/brseq_data_assemble.sv
module brseq_data_assemble #(
   parameter int HALF_W = 32,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap_hi,
   input  logic              cap_lo,
   input  logic              force_ones,
   input  logic [HALF_W-1:0] din,
   output logic [FULL_W-1:0] dout
);

   logic [HALF_W-1:0] hi_q;
   logic [HALF_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (clear) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (force_ones) begin
         hi_q <= '1;
         lo_q <= '1;
      end else begin
         if (cap_hi) hi_q <= din;
         if (cap_lo) lo_q <= din;
      end
   end

   assign dout = {hi_q, lo_q};

endmodule

// File: rtl/brseq_ctrl.sv
module brseq_ctrl
   import brseq_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int IDX_W  = 2,
   parameter int BUS_AW = 16,
   parameter int CODE_W = 8,
   parameter logic [CODE_W-1:0] HW_CODE = '1,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [HALF_W-1:0] req_addr,
   input  logic [FULL_W-1:0] req_wdata,
   input  logic [IDX_W-1:0]  req_target,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] rsp_code,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic              bus_write,
   output logic [BUS_AW-1:0] bus_addr,
   output logic [HALF_W-1:0] bus_wdata,
   input  logic [CODE_W-1:0] bus_err,
   input  stat_class_e       cls,
   output logic              kill,
   output logic [IDX_W-1:0]  kill_idx,
   output logic              data_clear,
   output logic              cap_hi,
   output logic              cap_lo,
   output logic              force_ones
);

   generate
      if (BUS_AW < 13) begin : g_bad_aw
         $error("bus address too narrow for bridge offsets");
      end
      if (HW_CODE == '0) begin : g_bad_code
         $error("hardware fault code must be nonzero");
      end
   endgenerate

   seq_state_e        state_q;
   logic              op_wr_q;
   logic [HALF_W-1:0] op_addr_q;
   logic [FULL_W-1:0] op_wdata_q;
   logic [IDX_W-1:0]  op_tgt_q;
   logic [CODE_W-1:0] code_q;

   logic              hs;
   logic              hs_bad;
   logic              hs_ok;
   logic              fail_now;
   logic [HALF_W-1:0] cmd_word;
   logic              accept;

   assign accept   = req_valid && (state_q == ST_IDLE);
   assign hs       = bus_valid && bus_ready;
   assign hs_bad   = hs && (bus_err != '0);
   assign hs_ok    = hs && (bus_err == '0);
   assign cmd_word = op_addr_q | {op_wr_q, {(HALF_W-1){1'b0}}};

   // bus request per state
   always_comb begin
      bus_valid = 1'b0;
      bus_write = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (state_q)
         ST_WR_HI: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = BUS_AW'(OFS_DATA_HI);
            bus_wdata = op_wdata_q[FULL_W-1:HALF_W];
         end
         ST_WR_LO: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = BUS_AW'(OFS_DATA_LO);
            bus_wdata = op_wdata_q[HALF_W-1:0];
         end
         ST_CMD: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = BUS_AW'(OFS_CMD);
            bus_wdata = cmd_word;
         end
         ST_STAT: begin
            bus_valid = 1'b1;
            bus_addr  = BUS_AW'(OFS_STATUS);
         end
         ST_RD_HI: begin
            bus_valid = 1'b1;
            bus_addr  = BUS_AW'(OFS_DATA_HI);
         end
         ST_RD_LO: begin
            bus_valid = 1'b1;
            bus_addr  = BUS_AW'(OFS_DATA_LO);
         end
         ST_RST: begin
            bus_valid = 1'b1;
            bus_write = 1'b1;
            bus_addr  = BUS_AW'(OFS_ENG_RST);
         end
         default: ;
      endcase
   end

   // failure events that close the access
   always_comb begin
      fail_now = 1'b0;
      if (hs && (state_q == ST_RST))
         fail_now = 1'b1;
      else if (hs_bad)
         fail_now = 1'b1;
      else if (hs_ok && (state_q == ST_STAT) && (cls == STAT_DEAD))
         fail_now = 1'b1;
   end

   assign kill       = hs_ok && (state_q == ST_STAT) && (cls == STAT_DEAD);
   assign kill_idx   = op_tgt_q;
   assign data_clear = accept;
   assign cap_hi     = hs_ok && (state_q == ST_RD_HI);
   assign cap_lo     = hs_ok && (state_q == ST_RD_LO);
   assign force_ones = fail_now && !op_wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_wr_q    <= 1'b0;
         op_addr_q  <= '0;
         op_wdata_q <= '0;
         op_tgt_q   <= '0;
         code_q     <= '0;
      end else begin
         if (state_q == ST_RST && hs)
            code_q <= HW_CODE;
         else if (hs_bad)
            code_q <= bus_err;
         else if (kill)
            code_q <= HW_CODE;

         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_wr_q    <= req_write;
                  op_addr_q  <= req_addr;
                  op_wdata_q <= req_wdata;
                  op_tgt_q   <= req_target;
                  code_q     <= '0;
                  state_q    <= req_write ? ST_WR_HI : ST_CMD;
               end
            end
            ST_WR_HI: if (hs) state_q <= hs_bad ? ST_DONE : ST_WR_LO;
            ST_WR_LO: if (hs) state_q <= hs_bad ? ST_DONE : ST_CMD;
            ST_CMD:   if (hs) state_q <= hs_bad ? ST_DONE : ST_STAT;
            ST_STAT: begin
               if (hs_bad)
                  state_q <= ST_DONE;
               else if (hs) begin
                  unique case (cls)
                     STAT_CLEAN:   state_q <= op_wr_q ? ST_DONE : ST_RD_HI;
                     STAT_DEAD:    state_q <= ST_DONE;
                     default:      state_q <= ST_RST;
                  endcase
               end
            end
            ST_RD_HI: if (hs) state_q <= hs_bad ? ST_DONE : ST_RD_LO;
            ST_RD_LO: if (hs) state_q <= ST_DONE;
            ST_RST:   if (hs) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign rsp_code  = code_q;

endmodule

// File: rtl/bridged_access_seq.sv
module bridged_access_seq
   import brseq_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter int NUM_TGT   = 4,
   parameter int BUS_AW    = 16,
   parameter int CODE_W    = 8,
   parameter int ABORT_BIT = 20,
   parameter int ERR_LSB   = 12,
   parameter int ERR_BITS  = 3,
   parameter logic [CODE_W-1:0] HW_CODE = '1,
   localparam int FULL_W = 2 * HALF_W,
   localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [HALF_W-1:0]  req_addr,
   input  logic [FULL_W-1:0]  req_wdata,
   input  logic [IDX_W-1:0]   req_target,
   output logic               busy,
   output logic               done,
   output logic [CODE_W-1:0]  rsp_code,
   output logic [FULL_W-1:0]  rsp_rdata,
   output logic [NUM_TGT-1:0] target_alive,
   output logic               bus_valid,
   input  logic               bus_ready,
   output logic               bus_write,
   output logic [BUS_AW-1:0]  bus_addr,
   output logic [HALF_W-1:0]  bus_wdata,
   input  logic [HALF_W-1:0]  bus_rdata,
   input  logic [CODE_W-1:0]  bus_err
);

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("half word too narrow");
      end
   endgenerate

   stat_class_e      cls;
   logic             kill;
   logic [IDX_W-1:0] kill_idx;
   logic             data_clear;
   logic             cap_hi;
   logic             cap_lo;
   logic             force_ones;

   brseq_status_classify #(
      .WORD_W   (HALF_W),
      .ABORT_BIT(ABORT_BIT),
      .ERR_LSB  (ERR_LSB),
      .ERR_BITS (ERR_BITS)
   ) i_classify (
      .status(bus_rdata),
      .cls   (cls)
   );

   brseq_ctrl #(
      .HALF_W (HALF_W),
      .IDX_W  (IDX_W),
      .BUS_AW (BUS_AW),
      .CODE_W (CODE_W),
      .HW_CODE(HW_CODE)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_target(req_target),
      .busy      (busy),
      .done      (done),
      .rsp_code  (rsp_code),
      .bus_valid (bus_valid),
      .bus_ready (bus_ready),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_err   (bus_err),
      .cls       (cls),
      .kill      (kill),
      .kill_idx  (kill_idx),
      .data_clear(data_clear),
      .cap_hi    (cap_hi),
      .cap_lo    (cap_lo),
      .force_ones(force_ones)
   );

   brseq_data_assemble #(
      .HALF_W(HALF_W)
   ) i_assemble (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (data_clear),
      .cap_hi    (cap_hi),
      .cap_lo    (cap_lo),
      .force_ones(force_ones),
      .din       (bus_rdata),
      .dout      (rsp_rdata)
   );

   brseq_alive_table #(
      .NUM_TGT(NUM_TGT),
      .IDX_W  (IDX_W)
   ) i_alive (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (kill),
      .kill_idx(kill_idx),
      .alive   (target_alive)
   );

endmodule

// File: rtl/brseq_checker.sv
module brseq_checker #(
   parameter int HALF_W    = 32,
   parameter int NUM_TGT   = 4,
   parameter int BUS_AW    = 16,
   parameter int CODE_W    = 8,
   parameter int ABORT_BIT = 20,
   parameter int ERR_LSB   = 12,
   parameter int ERR_BITS  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_write,
   input logic               busy,
   input logic               done,
   input logic [CODE_W-1:0]  rsp_code,
   input logic [2*HALF_W-1:0] rsp_rdata,
   input logic [NUM_TGT-1:0] target_alive,
   input logic               bus_valid,
   input logic               bus_ready,
   input logic               bus_write,
   input logic [BUS_AW-1:0]  bus_addr,
   input logic [HALF_W-1:0]  bus_wdata,
   input logic [HALF_W-1:0]  bus_rdata,
   input logic [CODE_W-1:0]  bus_err
);

   localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(16'h101C);
   localparam logic [BUS_AW-1:0] A_RST  = BUS_AW'(16'h1018);

   logic op_rd_q;
   logic stat_recover;

   always_ff @(posedge clk) begin
      if (!rst_n)
         op_rd_q <= 1'b0;
      else if (req_valid && req_ready)
         op_rd_q <= !req_write;
   end

   assign stat_recover = bus_valid && bus_ready && !bus_write && (bus_addr == A_STAT)
                         && (bus_err == '0) && !(&bus_rdata)
                         && (bus_rdata[ABORT_BIT] || (|bus_rdata[ERR_LSB +: ERR_BITS]));

   assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write)
                                     && $stable(bus_addr) && $stable(bus_wdata)));

   assert_bus_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (busy && !done));

   assert_bus_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && (bus_err != '0)) |=> (done && !bus_valid));

   assert_reset_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_recover |=> (bus_valid && bus_write && (bus_addr == A_RST) && (bus_wdata == '0)));

   assert_fail_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_rd_q && (rsp_code != '0)) |-> (&rsp_rdata));

   assert_alive_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((target_alive & ~$past(target_alive)) == '0));

   assert_alive_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones($past(target_alive)) - $countones(target_alive) <= 1));

endmodule

bind bridged_access_seq brseq_checker #(
   .HALF_W   (HALF_W),
   .NUM_TGT  (NUM_TGT),
   .BUS_AW   (BUS_AW),
   .CODE_W   (CODE_W),
   .ABORT_BIT(ABORT_BIT),
   .ERR_LSB  (ERR_LSB),
   .ERR_BITS (ERR_BITS)
) i_brseq_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_write   (req_write),
   .busy        (busy),
   .done        (done),
   .rsp_code    (rsp_code),
   .rsp_rdata   (rsp_rdata),
   .target_alive(target_alive),
   .bus_valid   (bus_valid),
   .bus_ready   (bus_ready),
   .bus_write   (bus_write),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .bus_err     (bus_err)
);

// File: tb/test_bridged_access_seq.sv
module test_bridged_access_seq;

   localparam logic [7:0] HW = 8'hFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [1:0]  req_target = '0;
   logic        busy;
   logic        done;
   logic [7:0]  rsp_code;
   logic [63:0] rsp_rdata;
   logic [3:0]  target_alive;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic        bus_write;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic [7:0]  bus_err = '0;

   bridged_access_seq i_bridged_access_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_target(req_target),
      .busy(busy), .done(done), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
      .target_alive(target_alive),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // responder configuration for the current access
   logic [31:0] cfg_stat;
   logic [31:0] cfg_hi;
   logic [31:0] cfg_lo;
   int          cfg_err_at;
   logic [7:0]  cfg_ecode;

   // observed accesses
   int          got_n;
   logic        got_wr [16];
   logic [15:0] got_addr [16];
   logic [31:0] got_wd [16];

   // expected accesses
   int          exp_n;
   logic        exp_wr [16];
   logic [15:0] exp_addr [16];
   logic [31:0] exp_wd [16];

   logic [3:0]  exp_alive = 4'hF;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit stat_clean(input logic [31:0] s);
      return (s & 32'h0010_7000) == 32'h0;
   endfunction

   task automatic push(input logic wr, input logic [15:0] a, input logic [31:0] d);
      exp_wr[exp_n]   = wr;
      exp_addr[exp_n] = a;
      exp_wd[exp_n]   = d;
      exp_n++;
   endtask

   // bus responder
   initial begin
      int dly;
      dly = 0;
      forever begin
         @(negedge clk);
         if (bus_ready) begin
            bus_ready = 1'b0;
            bus_err   = '0;
         end else if (bus_valid) begin
            if (dly > 0) dly--;
            else begin
               if (got_n < 16) begin
                  got_wr[got_n]   = bus_write;
                  got_addr[got_n] = bus_addr;
                  got_wd[got_n]   = bus_wdata;
               end
               bus_err = (got_n == cfg_err_at) ? cfg_ecode : 8'h00;
               if (!bus_write && bus_addr == 16'h101C)      bus_rdata = cfg_stat;
               else if (!bus_write && bus_addr == 16'h1000) bus_rdata = cfg_hi;
               else if (!bus_write && bus_addr == 16'h1004) bus_rdata = cfg_lo;
               else bus_rdata = $urandom;
               got_n++;
               bus_ready = 1'b1;
               dly = $urandom % 3;
            end
         end
      end
   end

   task automatic run_txn(input logic wr, input logic [31:0] addr, input logic [63:0] wd,
                          input logic [1:0] tgt, input logic [31:0] stat, input int err_at,
                          input logic [7:0] ecode);
      logic [31:0] cmd;
      logic [7:0]  exp_code;
      logic [63:0] exp_data;
      int          stat_idx;
      int          cyc;
      bit          seq_ok;
      string       seq_tag;
      cmd = addr | {wr, 31'h0};
      cfg_stat = stat; cfg_hi = $urandom; cfg_lo = $urandom;
      cfg_err_at = err_at; cfg_ecode = ecode;
      got_n = 0;
      exp_n = 0;
      // expected access list (R2, R3, R4, R7)
      if (wr) begin
         push(1'b1, 16'h1000, wd[63:32]);
         push(1'b1, 16'h1004, wd[31:0]);
      end
      push(1'b1, 16'h1008, cmd);
      stat_idx = exp_n;
      push(1'b0, 16'h101C, 32'h0);
      if (stat == 32'hFFFF_FFFF)
         exp_code = HW;
      else if (!stat_clean(stat)) begin
         push(1'b1, 16'h1018, 32'h0);
         exp_code = HW;
      end else begin
         exp_code = 8'h00;
         if (!wr) begin
            push(1'b0, 16'h1000, 32'h0);
            push(1'b0, 16'h1004, 32'h0);
         end
      end
      if (err_at < exp_n) begin
         exp_code = (exp_addr[err_at] == 16'h1018) ? HW : ecode;
         exp_n = err_at + 1;
      end
      if (stat == 32'hFFFF_FFFF && err_at > stat_idx)
         exp_alive[tgt] = 1'b0;
      if (wr) exp_data = 64'h0;
      else if (exp_code != 8'h00) exp_data = '1;
      else exp_data = {cfg_hi, cfg_lo};

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_target = tgt;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && !req_ready, "R1", "busy after accept", {62'h0, busy, req_ready}, 64'h2);
      cyc = 0;
      while (!done && cyc < 500) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         chk(1'b0, "R1", "watchdog", 64'(cyc), 64'd500);
         return;
      end
      seq_tag = wr ? "R2" : "R4";
      chk(rsp_code == exp_code, (err_at < exp_n) ? "R8" : (wr ? "R5" : "R4"), "rsp_code",
          64'(rsp_code), 64'(exp_code));
      chk(rsp_rdata == exp_data, "R9", "rsp_rdata", rsp_rdata, exp_data);
      seq_ok = (got_n == exp_n);
      for (int i = 0; i < exp_n && i < 16; i++) begin
         if (got_wr[i] != exp_wr[i] || got_addr[i] != exp_addr[i]) seq_ok = 0;
         if (exp_wr[i] && got_wd[i] != exp_wd[i]) seq_ok = 0;
      end
      chk(seq_ok, seq_tag, "access sequence (count)", 64'(got_n), 64'(exp_n));
      chk(target_alive == exp_alive, "R11", "target_alive", 64'(target_alive), 64'(exp_alive));
      @(negedge clk);
      chk(!done && req_ready && !busy, "R1", "done single cycle",
          {61'h0, done, req_ready, busy}, 64'h2);
   endtask

   initial begin
      int t0;
      t0 = 0;
      void'($urandom(32'd20240611));
      cfg_err_at = 99; cfg_ecode = 8'h00; cfg_stat = '0; cfg_hi = '0; cfg_lo = '0;
      got_n = 0; exp_n = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !busy && !done && !bus_valid, "R1", "reset state",
          {60'h0, req_ready, busy, done, bus_valid}, 64'h8);
      chk(target_alive == 4'hF, "R11", "alive after reset", 64'(target_alive), 64'hF);

      // R2 R5: clean write
      run_txn(1'b1, 32'h0000_1234, 64'h1122_3344_5566_7788, 2'd0, 32'h0000_0000, 99, 8'h00);
      // R4: clean read with unrelated status bits set
      run_txn(1'b0, 32'h0201_15CE, 64'h0, 2'd1, 32'h8000_0FFF, 99, 8'h00);
      // R3: read address with bit 31 already set
      run_txn(1'b0, 32'h8000_00F0, 64'h0, 2'd1, 32'h0, 99, 8'h00);
      // R7: abort bit on read, error field bits on writes
      run_txn(1'b0, 32'h0000_0010, 64'h0, 2'd0, 32'h0010_0000, 99, 8'h00);
      run_txn(1'b1, 32'h0000_0011, 64'hDEAD_BEEF_0BAD_F00D, 2'd0, 32'h0000_1000, 99, 8'h00);
      run_txn(1'b1, 32'h0000_0012, 64'h0123_4567_89AB_CDEF, 2'd3, 32'h0000_4000, 99, 8'h00);
      // R7: bus error on the reset write still yields the hardware code
      run_txn(1'b0, 32'h0000_0013, 64'h0, 2'd3, 32'h0000_2000, 2, 8'h33);
      // R6: dead target
      run_txn(1'b0, 32'h0000_0020, 64'h0, 2'd2, 32'hFFFF_FFFF, 99, 8'h00);
      // R8: bus errors at command, status and lower data read
      run_txn(1'b0, 32'h0000_0030, 64'h0, 2'd1, 32'h0, 0, 8'h05);
      run_txn(1'b1, 32'h0000_0031, 64'h5555_AAAA_5555_AAAA, 2'd1, 32'h0, 3, 8'h41);
      run_txn(1'b0, 32'h0000_0032, 64'h0, 2'd0, 32'h0, 3, 8'h7E);
      // R8 R6: bus error on the status read of a dead chip leaves the flag set
      run_txn(1'b0, 32'h0000_0033, 64'h0, 2'd3, 32'hFFFF_FFFF, 1, 8'h12);

      // random mix
      for (int n = 0; n < 150; n++) begin
         logic [31:0] st;
         int mode;
         int ea;
         mode = $urandom % 8;
         st = $urandom & ~32'h0010_7000;
         if (mode == 1) st = st | 32'h0010_0000;
         else if (mode == 2) st = st | (32'(($urandom % 7) + 1) << 12);
         else if (mode == 3 && ($urandom % 4) == 0) st = 32'hFFFF_FFFF;
         ea = (($urandom % 3) == 0) ? int'($urandom % 7) : 99;
         run_txn(1'($urandom), $urandom, {$urandom, $urandom}, 2'($urandom),
                 st, ea, 8'(($urandom % 127) + 1));
         t0++;
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // overall guard
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R1", "global watchdog", 64'h0, 64'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule